// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide. Software-side logic loads entries through a write port that names an address, and sets two configuration registers: a search argument and a key mask. A search strobe compares the argument against every valid entry at once. Only the bit positions where the key holds 1 take part. The per-entry result is captured in a match register, along with a count of the hits.

After a search, the matched entries are drained one per read strobe, lowest index first. Each read returns the entry's index and stored data, then removes it from the match register. An empty flag tells the consumer when nothing is left. A write that lands on an entry still waiting in the match register removes that entry's bit, so contents that have been replaced are never returned.

Top module: `mcam_top`

## Requirements
- R1: After reset, every entry is invalid, the match register is all zero, `hit_count` is 0, `none_left` is 1 and `rd_valid` is 0.
- R2: A clock edge with `wr_en` high stores `wr_data` at entry `wr_addr` and marks that entry valid. A later search with a matching argument reports that index and returns that data.
- R3: Only bit positions where the key register holds 1 are compared. Positions where the key is 0 always match, so a key of all zeros matches every valid entry.
- R4: An invalid entry never matches, whatever the argument and key are.
- R5: A search strobe loads the match register (`hit_map`, bit i for entry i) and `hit_count` at that clock edge, and both are visible in the next cycle. `hit_count` keeps the number of matches until the next search. The search uses the argument and key as they were before the edge, so a configuration write in the same cycle takes effect only for later searches.
- R6: A read strobe on a non-empty match register raises `rd_valid` for one cycle after the edge. `rd_index` and `rd_data` then give the lowest-indexed remaining matched entry, and that entry's bit in `hit_map` is cleared.
- R7: `none_left` is 1 exactly when `hit_map` is all zero. A read strobe while it is 1 leaves `rd_valid` at 0.
- R8: A write to an entry clears that entry's bit in the match register at the same edge. This also applies when a search strobe comes in the same cycle, and a read strobe in that cycle skips the entry.
- R9: When the search strobe and the read strobe come in the same cycle, the search is performed and the read is dropped: `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_we | input | 1 | Load `cfg_data` into the argument register |
| key_we | input | 1 | Load `cfg_data` into the key mask register |
| cfg_data | input | WIDTH | Configuration value |
| wr_en | input | 1 | Store `wr_data` at `wr_addr` |
| wr_addr | input | $clog2(WORDS) | Entry to write |
| wr_data | input | WIDTH | Data to store |
| search | input | 1 | Search strobe |
| rd_strobe | input | 1 | Pop the next matched entry |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_index | output | $clog2(WORDS) | Index of the entry returned |
| rd_data | output | WIDTH | Data of the entry returned |
| hit_map | output | WORDS | Remaining match bits |
| hit_count | output | $clog2(WORDS+1) | Matches found by the last search |
| none_left | output | 1 | No match bits remain |

## Verification
Every result is one register away from its strobe. `hit_map`, `hit_count` and `none_left` reflect a search or a write starting from the clock edge that samples the strobe. `rd_valid`, `rd_index` and `rd_data` become valid right after the edge that takes a read strobe. The bench drives each strobe on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. Expected read-outs are queued when the strobe is driven, and the monitor pops them in that same sampled cycle.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
    // operation chosen for the match register in a given cycle
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_SEARCH = 2'd1,
        OP_READ   = 2'd2
    } mcam_op_e;
endpackage

// File: rtl/mcam_store.sv
module mcam_store #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             arg_we,
    input  logic             key_we,
    input  logic [WIDTH-1:0] cfg_data,
    input  logic [IW-1:0]    sel_idx,
    output logic [WORDS-1:0] match_vec,
    output logic [WIDTH-1:0] sel_word
);
    typedef struct packed {
        logic [WORDS-1:0][WIDTH-1:0] data;
        logic [WORDS-1:0]            valid;
        logic [WIDTH-1:0]            arg;
        logic [WIDTH-1:0]            key;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.data[wr_addr]  = wr_data;
            st_d.valid[wr_addr] = 1'b1;
        end
        if (arg_we) st_d.arg = cfg_data;
        if (key_we) st_d.key = cfg_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.valid <= '0;
            st_q.arg   <= '0;
            st_q.key   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // parallel masked compare, one comparator per entry
    for (genvar w = 0; w < WORDS; w++) begin : g_cmp
        logic [WIDTH-1:0] bit_ok;
        assign bit_ok       = ~(st_q.arg ^ st_q.data[w]) | ~st_q.key;
        assign match_vec[w] = st_q.valid[w] & (&bit_ok);
    end

    assign sel_word = st_q.data[sel_idx];

    assert_write_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.valid[$past(wr_addr)]);

    assert_invalid_nomatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & ~st_q.valid) == '0);
endmodule

// File: rtl/mcam_pick.sv
module mcam_pick #(
    parameter int WORDS = 8,
    localparam int IW = $clog2(WORDS)
) (
    input  logic [WORDS-1:0] bits,
    output logic             any,
    output logic [IW-1:0]    idx,
    output logic [WORDS-1:0] onehot
);
    logic [WORDS:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < WORDS; i++) begin : g_chain
        assign onehot[i]  = bits[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | bits[i];
    end

    assign any = seen[WORDS];

    always_comb begin
        idx = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/mcam_readout.sv
module mcam_readout
    import mcam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IW = $clog2(WORDS),
    localparam int CW = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             search,
    input  logic             rd_strobe,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_addr,
    input  logic [WORDS-1:0] match_vec,
    input  logic [WIDTH-1:0] sel_word,
    output logic [IW-1:0]    sel_idx,
    output logic             rd_valid,
    output logic [IW-1:0]    rd_index,
    output logic [WIDTH-1:0] rd_data,
    output logic [WORDS-1:0] hit_map,
    output logic [CW-1:0]    hit_count,
    output logic             none_left
);
    typedef struct packed {
        logic [WORDS-1:0] match;
        logic [CW-1:0]    hits;
        logic             rvalid;
        logic [IW-1:0]    ridx;
        logic [WIDTH-1:0] rdata;
    } rdo_t;

    rdo_t             st_d, st_q;
    mcam_op_e         op;
    logic [WORDS-1:0] wr_mask;
    logic [WORDS-1:0] live;
    logic [WORDS-1:0] pick_oh;
    logic             pick_any;

    assign wr_mask = wr_en ? (WORDS'(1) << wr_addr) : '0;
    assign live    = st_q.match & ~wr_mask;

    mcam_pick #(.WORDS(WORDS)) u_pick (
        .bits   (live),
        .any    (pick_any),
        .idx    (sel_idx),
        .onehot (pick_oh)
    );

    always_comb begin
        if (search)         op = OP_SEARCH;
        else if (rd_strobe) op = OP_READ;
        else                op = OP_IDLE;
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.match  = live;
        case (op)
            OP_SEARCH: begin
                st_d.match = match_vec & ~wr_mask;
                st_d.hits  = CW'($countones(match_vec & ~wr_mask));
            end
            OP_READ: begin
                if (pick_any) begin
                    st_d.rvalid = 1'b1;
                    st_d.ridx   = sel_idx;
                    st_d.rdata  = sel_word;
                    st_d.match  = live & ~pick_oh;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid  = st_q.rvalid;
    assign rd_index  = st_q.ridx;
    assign rd_data   = st_q.rdata;
    assign hit_map   = st_q.match;
    assign hit_count = st_q.hits;
    assign none_left = ~|st_q.match;

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.match) <= int'(st_q.hits));

    assert_empty_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hits == '0) |-> none_left);

    assert_read_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !search && (live != '0)) |=> rd_valid);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !hit_map[rd_index]);

    assert_pick_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_oh));

    assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hit_map[$past(wr_addr)]);

    assert_search_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        search |=> !rd_valid);
endmodule

// File: rtl/mcam_top.sv
module mcam_top #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IW = $clog2(WORDS),
    localparam int CW = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arg_we,
    input  logic             key_we,
    input  logic [WIDTH-1:0] cfg_data,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             search,
    input  logic             rd_strobe,
    output logic             rd_valid,
    output logic [IW-1:0]    rd_index,
    output logic [WIDTH-1:0] rd_data,
    output logic [WORDS-1:0] hit_map,
    output logic [CW-1:0]    hit_count,
    output logic             none_left
);
    logic [WORDS-1:0] match_vec;
    logic [WIDTH-1:0] sel_word;
    logic [IW-1:0]    sel_idx;

    mcam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .arg_we    (arg_we),
        .key_we    (key_we),
        .cfg_data  (cfg_data),
        .sel_idx   (sel_idx),
        .match_vec (match_vec),
        .sel_word  (sel_word)
    );

    mcam_readout #(.WORDS(WORDS), .WIDTH(WIDTH)) u_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .search    (search),
        .rd_strobe (rd_strobe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .match_vec (match_vec),
        .sel_word  (sel_word),
        .sel_idx   (sel_idx),
        .rd_valid  (rd_valid),
        .rd_index  (rd_index),
        .rd_data   (rd_data),
        .hit_map   (hit_map),
        .hit_count (hit_count),
        .none_left (none_left)
    );
endmodule

// File: tb/test_mcam_top.sv
module test_mcam_top;
    localparam int WORDS = 8;
    localparam int WIDTH = 16;
    localparam int IW = $clog2(WORDS);
    localparam int CW = $clog2(WORDS + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arg_we = 1'b0, key_we = 1'b0;
    logic [WIDTH-1:0] cfg_data = '0;
    logic             wr_en = 1'b0;
    logic [IW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             search = 1'b0, rd_strobe = 1'b0;
    logic             rd_valid;
    logic [IW-1:0]    rd_index;
    logic [WIDTH-1:0] rd_data;
    logic [WORDS-1:0] hit_map;
    logic [CW-1:0]    hit_count;
    logic             none_left;

    always #5 clk = ~clk;

    mcam_top #(.WORDS(WORDS), .WIDTH(WIDTH)) i_mcam_top (
        .clk(clk), .rst_n(rst_n), .arg_we(arg_we), .key_we(key_we),
        .cfg_data(cfg_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .search(search), .rd_strobe(rd_strobe),
        .rd_valid(rd_valid), .rd_index(rd_index), .rd_data(rd_data),
        .hit_map(hit_map), .hit_count(hit_count), .none_left(none_left)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model, built from the requirements
    logic [WIDTH-1:0] m_mem [WORDS];
    logic [WORDS-1:0] m_vld = '0;
    logic [WIDTH-1:0] m_arg = '0;
    logic [WIDTH-1:0] m_key = '1;
    logic [WORDS-1:0] m_bits = '0;

    int               q_idx [$];
    logic [WIDTH-1:0] q_dat [$];
    string            q_req [$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORDS-1:0] model_match();
        logic [WORDS-1:0] r = '0;
        for (int i = 0; i < WORDS; i++)
            r[i] = m_vld[i] && (((m_arg ^ m_mem[i]) & m_key) == '0);
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [WIDTH-1:0] d);
        wr_en = 1'b1; wr_addr = IW'(a); wr_data = d;
        tick();
        wr_en = 1'b0;
        m_mem[a] = d; m_vld[a] = 1'b1; m_bits[a] = 1'b0;
    endtask

    task automatic set_arg(input logic [WIDTH-1:0] d);
        arg_we = 1'b1; cfg_data = d;
        tick();
        arg_we = 1'b0; m_arg = d;
    endtask

    task automatic set_key(input logic [WIDTH-1:0] d);
        key_we = 1'b1; cfg_data = d;
        tick();
        key_we = 1'b0; m_key = d;
    endtask

    task automatic check_map(input string req);
        chk(req, "hit_map", int'(hit_map), int'(m_bits));
        chk(req, "none_left", int'(none_left), int'(m_bits == '0));
    endtask

    task automatic do_search(input string req);
        m_bits = model_match();
        search = 1'b1;
        tick();
        search = 1'b0;
        check_map(req);
        chk(req, "hit_count", int'(hit_count), $countones(m_bits));
    endtask

    // search in the same cycle as an argument write: old argument applies
    task automatic search_with_arg(input string req, input logic [WIDTH-1:0] d);
        m_bits = model_match();
        search = 1'b1; arg_we = 1'b1; cfg_data = d;
        tick();
        search = 1'b0; arg_we = 1'b0; m_arg = d;
        check_map(req);
        chk(req, "hit_count", int'(hit_count), $countones(m_bits));
    endtask

    // search and read strobes together: read is dropped
    task automatic search_and_read(input string req);
        m_bits = model_match();
        search = 1'b1; rd_strobe = 1'b1;
        tick();
        search = 1'b0; rd_strobe = 1'b0;
        chk(req, "rd_valid", int'(rd_valid), 0);
        check_map(req);
    endtask

    task automatic do_read(input string req);
        bit had = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            if (!had && m_bits[i]) begin
                had = 1'b1;
                q_idx.push_back(i); q_dat.push_back(m_mem[i]); q_req.push_back(req);
                m_bits[i] = 1'b0;
            end
        end
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
        chk(req, "rd_valid", int'(rd_valid), int'(had));
        check_map(req);
    endtask

    // monitor: compares each read result with the queued expectation
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_idx.size() == 0) begin
                chk("R6", "unexpected read", 1, 0);
            end else begin
                automatic int               ei = q_idx.pop_front();
                automatic logic [WIDTH-1:0] ed = q_dat.pop_front();
                automatic string            er = q_req.pop_front();
                chk(er, "rd_index", int'(rd_index), ei);
                chk(er, "rd_data", int'(rd_data), int'(ed));
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "none_left", int'(none_left), 1);
        chk("R1", "hit_count", int'(hit_count), 0);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "hit_map", int'(hit_map), 0);
        // R1 / R4: all entries invalid, even a key of zero finds nothing
        set_key('0);
        do_search("R4");
        do_read("R7");

        // R2: load entries
        do_write(0, 16'h1234);
        do_write(1, 16'hABCD);
        do_write(3, 16'h1299);
        do_write(5, 16'h5634);
        do_write(7, 16'h1234);

        // R2 / R6: full compare, drained lowest first
        set_key('1);
        set_arg(16'h1234);
        do_search("R2");
        do_read("R6");
        do_read("R6");
        do_read("R7");   // empty: no rd_valid

        // R3: partial key
        set_key(16'h00FF);
        set_arg(16'h0034);
        do_search("R3");
        do_read("R6");
        // R8: overwrite entry 5 with data that would still match
        do_write(5, 16'h0034);
        check_map("R8");
        do_read("R8");
        do_read("R7");

        // R3 / R4: zero key matches only the valid entries
        set_key('0);
        do_search("R3");
        for (int k = 0; k < 6; k++) do_read("R4");

        // R5: argument written in the search cycle is not used
        set_key('1);
        set_arg(16'hABCD);
        search_with_arg("R5", 16'h1234);
        do_search("R5");

        // R9: search beats read; result is the new search
        set_arg(16'h1299);
        search_and_read("R9");
        do_read("R9");
        do_read("R7");

        repeat (2) @(negedge clk);
        chk("R6", "pending reads", q_idx.size(), 0);
        summary();
        finished = 1'b1;
        $finish;
    end
endmodule